// File: doc/BRIEF.md
# Two-Bit Branch Direction Predictor Table

This block holds a direct-mapped array of two-bit saturating counters that guess whether a conditional branch will be taken. The front end presents the branch PC in the stage where the branch address is computed and decode begins. A low slice of the PC selects one counter, and that counter's state gives a taken or not-taken guess in the same cycle. A taken guess raises a redirect request, and the surrounding pipeline then steers fetch to the computed target. With no redirect, fetch goes on at the next sequential word. Jumps, whether direct or through a register, do not read the table. They are always treated as taken, so they always request a redirect.

The real direction becomes known later, at the end of the register-read stage. At that point the resolved outcome is written back through a separate update port and moves the selected counter by one step.

The state encoding is the reverse of the common convention. A counter whose upper bit is 0 predicts taken, and one whose upper bit is 1 predicts not taken. Every counter leaves reset as 11, which is the strongest not-taken state.

Top module: `bht_predictor`

## Requirements
- R1: After reset every counter holds 11, so a conditional lookup at any index gives pred_taken=0 and redirect=0.
- R2: A conditional lookup gives pred_taken=1 exactly when the selected counter's upper bit is 0 (states 00 and 01), and pred_taken=0 for states 10 and 11. For a conditional lookup, redirect equals pred_taken.
- R3: An update with taken=1 moves the selected counter one step toward 00 (11→10→01→00) and leaves it at 00 if it is already there.
- R4: An update with taken=0 moves the selected counter one step toward 11 (00→01→10→11) and leaves it at 11 if it is already there.
- R5: Both ports select the counter with PC bits [IDX_W+1:2]. Other PC bits have no effect on the selection, and an update changes only the counter it selects.
- R6: A valid lookup with is_cond=0 (a jump) gives redirect=1 and pred_taken=0, and it leaves every counter unchanged.
- R7: With lk_valid=0, both pred_taken and redirect are 0.
- R8: If a lookup and an update select the same counter in the same cycle, the lookup reports the state from before the update. The new state shows from the next cycle on.
- R9: With upd_valid=0, no counter changes, whatever upd_pc and upd_taken hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | A branch or jump is present in the lookup stage |
| lk_pc | input | PC_W | PC of the instruction being looked up |
| lk_is_cond | input | 1 | 1 for a conditional branch, 0 for a jump |
| upd_valid | input | 1 | A resolved conditional branch outcome is present |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Resolved direction, 1 = taken |
| pred_taken | output | 1 | Table guess for a conditional lookup, 1 = taken |
| redirect | output | 1 | Request to steer fetch to the computed target |

## Verification
A counter that holds a wrong state only shows at the ports when that index is looked up with a conditional lookup. Even then it shows only if the error crosses the upper-bit boundary. An error between 00 and 01, or between 10 and 11, stays hidden until one or two further updates in the opposite direction flip the guess. For this reason the bench pushes each counter through its whole range in both directions and looks it up after every step, so a wrong step or a wrong saturation point is seen within one to three cycles. An update written to the wrong index shows on the next lookup of either the intended counter or the one actually hit. Random traffic on a small table makes same-cycle collisions and such aliasing frequent.

// File: rtl/bht_pkg.sv
package bht_pkg;

    typedef enum logic [1:0] {
        DIR_STRONG_T  = 2'b00,
        DIR_WEAK_T    = 2'b01,
        DIR_WEAK_NT   = 2'b10,
        DIR_STRONG_NT = 2'b11
    } dir_state_e;

    localparam dir_state_e DIR_RESET = DIR_STRONG_NT;

    typedef struct packed {
        logic pred_taken;
        logic redirect;
    } bht_decision_t;

    // Upper bit clear means the branch is guessed taken.
    function automatic logic guess_taken(input dir_state_e s);
        return ~s[1];
    endfunction

    // Saturating step: taken walks toward 00, not taken toward 11.
    function automatic dir_state_e step_state(input dir_state_e s, input logic taken);
        dir_state_e n;
        n = s;
        if (taken) begin
            if (s != DIR_STRONG_T) n = dir_state_e'(s - 2'd1);
        end else begin
            if (s != DIR_STRONG_NT) n = dir_state_e'(s + 2'd1);
        end
        return n;
    endfunction

endpackage

// File: rtl/bht_counter_bank.sv
module bht_counter_bank
    import bht_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output dir_state_e       rd_state,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);
    localparam int ENTRIES = 1 << IDX_W;

    dir_state_e ctr [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) ctr[i] <= DIR_RESET;
        end else if (wr_en) begin
            ctr[wr_idx] <= step_state(ctr[wr_idx], wr_taken);
        end
    end

    // Read sees the registered state, so a same-cycle write is not visible yet.
    assign rd_state = ctr[rd_idx];

    genvar g;
    generate
        for (g = 0; g < ENTRIES; g++) begin : g_chk
            // R3
            taken_step_chk: assert property (@(posedge clk) disable iff (rst)
                (wr_en && wr_idx == IDX_W'(g) && wr_taken && ctr[g] != DIR_STRONG_T)
                |=> (ctr[g] == dir_state_e'($past(ctr[g]) - 2'd1)));
            // R4
            nottaken_step_chk: assert property (@(posedge clk) disable iff (rst)
                (wr_en && wr_idx == IDX_W'(g) && !wr_taken && ctr[g] != DIR_STRONG_NT)
                |=> (ctr[g] == dir_state_e'($past(ctr[g]) + 2'd1)));
            // R9
            idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
                !(wr_en && wr_idx == IDX_W'(g)) |=> $stable(ctr[g]));
        end
    endgenerate

endmodule

// File: rtl/bht_decide.sv
module bht_decide
    import bht_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          lk_valid,
    input  logic          lk_is_cond,
    input  dir_state_e    state,
    output bht_decision_t decision
);
    always_comb begin
        decision = '0;
        if (lk_valid) begin
            if (lk_is_cond) begin
                decision.pred_taken = guess_taken(state);
                decision.redirect   = guess_taken(state);
            end else begin
                decision.redirect   = 1'b1;
            end
        end
    end

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |-> (decision == '0));
    // R6
    jump_redirect_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && !lk_is_cond) |-> (decision.redirect && !decision.pred_taken));
    // R2
    cond_agree_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_is_cond) |-> (decision.redirect == decision.pred_taken));

endmodule

// File: rtl/bht_predictor.sv
module bht_predictor
    import bht_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            lk_valid,
    input  logic [PC_W-1:0] lk_pc,
    input  logic            lk_is_cond,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    output logic            pred_taken,
    output logic            redirect
);
    localparam int IDX_LO = 2;
    localparam int IDX_HI = IDX_LO + IDX_W - 1;

    logic [IDX_W-1:0] lk_idx;
    logic [IDX_W-1:0] upd_idx;
    dir_state_e       lk_state;
    bht_decision_t    decision;

    assign lk_idx  = lk_pc[IDX_HI:IDX_LO];
    assign upd_idx = upd_pc[IDX_HI:IDX_LO];

    logic unused_pc_bits;
    assign unused_pc_bits = ^{lk_pc[PC_W-1:IDX_HI+1], lk_pc[IDX_LO-1:0],
                              upd_pc[PC_W-1:IDX_HI+1], upd_pc[IDX_LO-1:0]};

    bht_counter_bank #(.IDX_W(IDX_W)) bank_i (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (lk_idx),
        .rd_state (lk_state),
        .wr_en    (upd_valid),
        .wr_idx   (upd_idx),
        .wr_taken (upd_taken)
    );

    bht_decide decide_i (
        .clk        (clk),
        .rst        (rst),
        .lk_valid   (lk_valid),
        .lk_is_cond (lk_is_cond),
        .state      (lk_state),
        .decision   (decision)
    );

    assign pred_taken = decision.pred_taken;
    assign redirect   = decision.redirect;

endmodule

// File: tb/bht_predictor_tb_top.sv
module bht_predictor_tb_top;
    localparam int PC_W  = 32;
    localparam int IDX_W = 4;
    localparam int ENT   = 1 << IDX_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lk_valid = 1'b0, lk_is_cond = 1'b0, upd_valid = 1'b0, upd_taken = 1'b0;
    logic [PC_W-1:0] lk_pc = '0, upd_pc = '0;
    logic pred_taken, redirect;

    int total = 0;
    int bad   = 0;
    int model [ENT];
    bit done = 1'b0;

    always #5 clk = ~clk;

    bht_predictor #(.PC_W(PC_W), .IDX_W(IDX_W)) dut_i (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_pc(lk_pc),
        .lk_is_cond(lk_is_cond), .upd_valid(upd_valid), .upd_pc(upd_pc),
        .upd_taken(upd_taken), .pred_taken(pred_taken), .redirect(redirect)
    );

    function automatic int idx_of(input logic [PC_W-1:0] pc);
        return int'(pc[IDX_W+1:2]);
    endfunction

    function automatic logic exp_pred(input logic v, input logic c, input int s);
        return v && c && (s < 2);
    endfunction

    function automatic logic exp_redir(input logic v, input logic c, input int s);
        return v && (!c || s < 2);
    endfunction

    function automatic int next_model(input int s, input logic t);
        if (t) return (s > 0) ? s - 1 : 0;
        return (s < 3) ? s + 1 : 3;
    endfunction

    task automatic step(input logic lv, input logic [PC_W-1:0] lpc, input logic lc,
                        input logic uv, input logic [PC_W-1:0] upc, input logic ut,
                        input string req);
        logic ep, er;
        @(negedge clk);
        lk_valid = lv; lk_pc = lpc; lk_is_cond = lc;
        upd_valid = uv; upd_pc = upc; upd_taken = ut;
        #1;
        ep = exp_pred(lv, lc, model[idx_of(lpc)]);
        er = exp_redir(lv, lc, model[idx_of(lpc)]);
        total++;
        if (pred_taken !== ep || redirect !== er) begin
            bad++;
            $display("FAIL %s: pc=%h pred=%b redir=%b expected pred=%b redir=%b",
                     req, lpc, pred_taken, redirect, ep, er);
        end
        @(posedge clk);
        if (uv) model[idx_of(upc)] = next_model(model[idx_of(upc)], ut);
    endtask

    task automatic look(input logic [PC_W-1:0] pc, input string req);
        step(1'b1, pc, 1'b1, 1'b0, '0, 1'b0, req);
    endtask

    task automatic upd(input logic [PC_W-1:0] pc, input logic t, input string req);
        step(1'b0, '0, 1'b0, 1'b1, pc, t, req);
        look(pc, req);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < ENT; i++) model[i] = 3;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: every entry starts strongly not taken
        for (int i = 0; i < ENT; i++) look(32'(i * 4), "R1");

        // R3: walk entry 3 down to 00 and past it
        for (int k = 0; k < 5; k++) upd(32'h0000_000C, 1'b1, "R3");
        // R4: walk it back up to 11 and past it
        for (int k = 0; k < 5; k++) upd(32'h0000_000C, 1'b0, "R4");
        // R2: the weak states 10 and 01 on entry 7
        upd(32'h0000_001C, 1'b1, "R2");
        upd(32'h0000_001C, 1'b1, "R2");

        // R5: upper and low PC bits ignored, neighbours untouched
        upd(32'hABC0_0017, 1'b1, "R5");
        upd(32'h5550_0015, 1'b1, "R5");
        look(32'h0000_0014, "R5");
        look(32'h0000_0010, "R5");
        look(32'h0000_0018, "R5");

        // R6: jumps redirect and do not disturb the table
        step(1'b1, 32'h0000_0020, 1'b0, 1'b0, '0, 1'b0, "R6");
        step(1'b1, 32'h0000_0020, 1'b0, 1'b0, '0, 1'b0, "R6");
        look(32'h0000_0020, "R6");

        // R7: no lookup, outputs quiet
        step(1'b0, 32'h0000_0014, 1'b1, 1'b0, '0, 1'b0, "R7");

        // R8: collision on entry 9 (state 11 -> 10 -> 01)
        step(1'b1, 32'h0000_0024, 1'b1, 1'b1, 32'h0000_0024, 1'b1, "R8");
        step(1'b1, 32'h0000_0024, 1'b1, 1'b1, 32'h0000_0024, 1'b1, "R8");
        look(32'h0000_0024, "R8");

        // R9: update port idle with noise on its data
        for (int k = 0; k < 4; k++)
            step(1'b0, '0, 1'b0, 1'b0, 32'h0000_0028, 1'b1, "R9");
        look(32'h0000_0028, "R9");

        // Random mix of all of the above
        for (int n = 0; n < 2000; n++) begin
            logic [PC_W-1:0] a, b;
            a = $urandom;
            b = $urandom;
            if ($urandom_range(0, 3) == 0) b = a;
            step(1'($urandom_range(0, 3) != 0), a, 1'($urandom_range(0, 3) != 0),
                 1'($urandom_range(0, 1)), b, 1'($urandom_range(0, 1)), "R2");
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule